// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers a parameterised set of interrupt request lines (32 by default) and merges them into one upstream interrupt line. Each input first passes through a multi-flop synchroniser. Software then chooses, per input, whether the line is sampled as an edge event or as a level, and which polarity counts as active. Edge events are caught in a sticky pending register that software clears by writing ones. Level inputs keep their pending bit equal to the qualified level on every cycle. A force register lets software inject a request on any bit. A per-input enable mask selects which pending bits may reach the merged line.

The merged request is the OR of pending bits that are enabled. It is shaped by an output stage that has its own mode bit and polarity bit. In level mode the line simply follows the request. In edge mode each new rise of the request gives a one-cycle pulse. The bit encoding is the same as for the inputs. With both output bits at zero, which is the reset value, the line is a level that is active low. Software reaches the controller through a plain synchronous bus: address, write strobe, write data, and combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is held, every register reads 0 and `irq_o` is 1, because the output is an inactive active-low level.
- R2: An edge-mode input (mode bit = 1) with polarity bit = 1 sets its pending bit on a 0-to-1 transition. The bit stays set after the input returns low.
- R3: An edge-mode input with polarity bit = 0 sets its pending bit only on a 1-to-0 transition. A 0-to-1 transition leaves the bit clear.
- R4: Writing 1 to a bit at offset 0x04 clears that edge-mode pending bit. Writing 0 to it leaves the bit unchanged.
- R5: A level-mode input (mode bit = 0) has its pending bit follow the qualified level. The level is active high when the polarity bit is 1 and active low when it is 0. A write-1 clear has no lasting effect while the level is active.
- R6: A 1 in the force register (offset 0x18) holds the matching pending bit at 1 whatever the input does. After the force bit is removed, an edge-mode bit stays pending until it is cleared.
- R7: A pending bit reaches `irq_o` only when its enable bit (offset 0x00) is 1. With no enabled pending bit, `irq_o` is inactive.
- R8: With output mode bit (offset 0x10, bit 0) = 0, `irq_o` is a level. It is active high when the output polarity bit (offset 0x14, bit 0) is 1 and active low when that bit is 0.
- R9: With output mode bit = 1, each 0-to-1 change of the merged request gives exactly one active cycle on `irq_o` in the programmed polarity. A request that stays high gives no further pulse.
- R10: Enable (0x00), input mode (0x08), input polarity (0x0C) and force (0x18) read back as written. Any unmapped offset reads 0.
- R11: An input change made just after clock edge 0 is visible in the pending register after edge 3. It is not visible after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt request inputs |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Merged upstream interrupt line |

## Verification
A corrupted pending bit shows up on the next read of offset 0x04. If that bit is enabled, it also shows on `irq_o` one cycle after the pending register changes. A broken synchroniser or edge history moves the first visible pending bit away from the third clock edge, or sets it on the wrong transition, and this is caught within a few cycles of the stimulus. A wrong request history in the output stage gives a pulse train or a missing pulse in edge mode, which the pulse-count checks catch within the same short window.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   // Byte offsets of the register file; software drivers depend on these.
   localparam logic [31:0] OFS_ENABLE  = 32'h00;
   localparam logic [31:0] OFS_PEND    = 32'h04;
   localparam logic [31:0] OFS_SMODE   = 32'h08;
   localparam logic [31:0] OFS_SPOL    = 32'h0C;
   localparam logic [31:0] OFS_OMODE   = 32'h10;
   localparam logic [31:0] OFS_OPOL    = 32'h14;
   localparam logic [31:0] OFS_FORCE   = 32'h18;

   typedef enum logic [2:0] {
      SEL_ENABLE,
      SEL_PEND,
      SEL_SMODE,
      SEL_SPOL,
      SEL_OMODE,
      SEL_OPOL,
      SEL_FORCE,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irqagg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irqagg_sync: W must be positive");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q[0] <= '0;
      end else begin
         chain_q[0] <= async_i;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp_i,
   input  logic [W-1:0] mode_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] force_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] hist_q;
   logic [W-1:0] pend_q;
   logic [W-1:0] lvl;
   logic [W-1:0] evt;
   logic [W-1:0] pend_d;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic rise, fall;
      assign rise = smp_i[i] & ~hist_q[i];
      assign fall = ~smp_i[i] & hist_q[i];
      assign evt[i] = pol_i[i] ? rise : fall;
      assign lvl[i] = pol_i[i] ? smp_i[i] : ~smp_i[i];
      // Edge bits are sticky with set winning over clear; level bits track.
      assign pend_d[i] = force_i[i] |
                         (mode_i[i] ? ((pend_q[i] & ~clr_i[i]) | evt[i]) : lvl[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         pend_q <= '0;
      end else begin
         hist_q <= smp_i;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   // R2 / R4: a set edge bit only drops when software clears it
   p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_q & mode_i & ~clr_i) & ~pend_q) == '0));

   // R5: an active level always leaves its pending bit set
   p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(lvl & ~mode_i) & ~pend_q) == '0));

   // R5: an inactive, unforced level always leaves its pending bit clear
   p_level_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~lvl & ~mode_i & ~force_i) & pend_q) == '0));

   // R6: a forced bit is pending on the following cycle
   p_force_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(force_i) & ~pend_q) == '0));

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
   import irqagg_pkg::*;
#(
   parameter int W      = 32,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [W-1:0]      pend_i,
   output logic [W-1:0]      enable_o,
   output logic [W-1:0]      smode_o,
   output logic [W-1:0]      spol_o,
   output logic [W-1:0]      force_o,
   output logic [W-1:0]      clr_o,
   output logic              omode_o,
   output logic              opol_o
);

   if (W < 1 || W > DATA_W) begin : g_bad_w
      $error("irqagg_regs: W must be in 1..DATA_W");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("irqagg_regs: ADDR_W must be in 5..32");
   end

   logic [31:0] addr_ext;
   reg_sel_e    sel;
   logic [W-1:0] enable_q, smode_q, spol_q, force_q;
   logic         omode_q, opol_q;

   assign addr_ext = 32'(bus_addr);

   always_comb begin
      case (addr_ext)
         OFS_ENABLE: sel = SEL_ENABLE;
         OFS_PEND:   sel = SEL_PEND;
         OFS_SMODE:  sel = SEL_SMODE;
         OFS_SPOL:   sel = SEL_SPOL;
         OFS_OMODE:  sel = SEL_OMODE;
         OFS_OPOL:   sel = SEL_OPOL;
         OFS_FORCE:  sel = SEL_FORCE;
         default:    sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         smode_q  <= '0;
         spol_q   <= '0;
         force_q  <= '0;
         omode_q  <= 1'b0;
         opol_q   <= 1'b0;
      end else if (bus_we) begin
         case (sel)
            SEL_ENABLE: enable_q <= bus_wdata[W-1:0];
            SEL_SMODE:  smode_q  <= bus_wdata[W-1:0];
            SEL_SPOL:   spol_q   <= bus_wdata[W-1:0];
            SEL_FORCE:  force_q  <= bus_wdata[W-1:0];
            SEL_OMODE:  omode_q  <= bus_wdata[0];
            SEL_OPOL:   opol_q   <= bus_wdata[0];
            default:    ;
         endcase
      end
   end

   assign clr_o = (bus_we && sel == SEL_PEND) ? bus_wdata[W-1:0] : '0;

   always_comb begin
      case (sel)
         SEL_ENABLE: bus_rdata = DATA_W'(enable_q);
         SEL_PEND:   bus_rdata = DATA_W'(pend_i);
         SEL_SMODE:  bus_rdata = DATA_W'(smode_q);
         SEL_SPOL:   bus_rdata = DATA_W'(spol_q);
         SEL_OMODE:  bus_rdata = DATA_W'(omode_q);
         SEL_OPOL:   bus_rdata = DATA_W'(opol_q);
         SEL_FORCE:  bus_rdata = DATA_W'(force_q);
         default:    bus_rdata = '0;
      endcase
   end

   assign enable_o = enable_q;
   assign smode_o  = smode_q;
   assign spol_o   = spol_q;
   assign force_o  = force_q;
   assign omode_o  = omode_q;
   assign opol_o   = opol_q;

   // R10: offsets outside the map return zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: rtl/irqagg_outstage.sv
module irqagg_outstage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend_i,
   input  logic [W-1:0] enable_i,
   input  logic         omode_i,
   input  logic         opol_i,
   output logic         irq_o
);

   logic req, req_q, act, act_q, out_q;

   assign req = |(pend_i & enable_i);
   assign act = omode_i ? (req & ~req_q) : req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         act_q <= 1'b0;
         out_q <= 1'b1;   // inactive for the reset polarity (active low)
      end else begin
         req_q <= req;
         act_q <= act;
         out_q <= opol_i ? act : ~act;
      end
   end

   assign irq_o = out_q;

   // R9: in pulse mode an active cycle is never followed by another
   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && omode_i) |=> !act_q);

   // R8: the line equals the polarity-adjusted activity of the cycle before
   p_out_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == ($past(opol_i) ? act_q : ~act_q)));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_nsrc
      $error("irq_aggregator: NUM_SRC must be in 1..DATA_W");
   end

   logic [NUM_SRC-1:0] smp, pend, enable, smode, spol, frc, clr;
   logic               omode, opol;

   irqagg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (src_i),
      .sync_o  (smp)
   );

   irqagg_pending #(.W(NUM_SRC)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_i   (smp),
      .mode_i  (smode),
      .pol_i   (spol),
      .force_i (frc),
      .clr_i   (clr),
      .pend_o  (pend)
   );

   irqagg_regs #(.W(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pend_i    (pend),
      .enable_o  (enable),
      .smode_o   (smode),
      .spol_o    (spol),
      .force_o   (frc),
      .clr_o     (clr),
      .omode_o   (omode),
      .opol_o    (opol)
   );

   irqagg_outstage #(.W(NUM_SRC)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend),
      .enable_i (enable),
      .omode_i  (omode),
      .opol_i   (opol),
      .irq_o    (irq_o)
   );

   // R7: with nothing enabled and pending the line goes inactive next cycle
   p_masked_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & enable) == '0) |=> (irq_o == ~$past(opol)));

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

   localparam int NS = 32;
   localparam logic [4:0] A_EN = 5'h00, A_PEND = 5'h04, A_SMODE = 5'h08,
                          A_SPOL = 5'h0C, A_OMODE = 5'h10, A_OPOL = 5'h14,
                          A_FORCE = 5'h18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [4:0]    bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o;

   int total = 0;
   int bad = 0;
   logic [31:0] sh_mode, sh_pol;

   always #2.5 clk = ~clk;

   irq_aggregator dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic count_level(input int n, input logic v, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (irq_o === v) c++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic [4:0] lst [8] = '{A_EN, A_PEND, A_SMODE, A_SPOL, A_OMODE, A_OPOL, A_FORCE, 5'h1C};
      foreach (lst[k]) begin
         rd(lst[k], d);
         chk("R1 reset register", d, 32'h0);
      end
      chk("R1 reset irq_o", {31'h0, irq_o}, 32'h1);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wr(A_EN, 32'hA5C3_0F1E);
      rd(A_EN, d);  chk("R10 enable readback", d, 32'hA5C3_0F1E);
      wr(A_EN, 32'h0);
      rd(A_SMODE, d); chk("R10 mode readback", d, sh_mode);
      rd(A_SPOL, d);  chk("R10 polarity readback", d, sh_pol);
      rd(5'h1C, d);   chk("R10 unmapped 0x1C", d, 32'h0);
      rd(5'h02, d);   chk("R10 unmapped 0x02", d, 32'h0);
   endtask

   task automatic t_sync_and_edge();
      logic [31:0] d;
      @(negedge clk);
      bus_addr = A_PEND;
      src[0] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R11 not visible after edge 2", {31'h0, bus_rdata[0]}, 32'h0);
      @(posedge clk); #1;
      chk("R11 visible after edge 3", {31'h0, bus_rdata[0]}, 32'h1);
      @(negedge clk); src[0] = 1'b0;
      idle(5);
      rd(A_PEND, d); chk("R2 rising edge held", d, 32'h1);
      wr(A_PEND, 32'h0);
      rd(A_PEND, d); chk("R4 write 0 keeps bit", d, 32'h1);
      wr(A_PEND, 32'h1);
      rd(A_PEND, d); chk("R4 write 1 clears bit", d, 32'h0);
   endtask

   task automatic t_falling();
      logic [31:0] d;
      sh_pol = ~32'h2;
      wr(A_SPOL, sh_pol);
      @(negedge clk); src[1] = 1'b1;
      idle(5);
      rd(A_PEND, d); chk("R3 rise ignored on falling source", d, 32'h0);
      @(negedge clk); src[1] = 1'b0;
      idle(5);
      rd(A_PEND, d); chk("R3 fall sets bit", d, 32'h2);
      wr(A_PEND, 32'h2);
      sh_pol = 32'hFFFF_FFFF;
      wr(A_SPOL, sh_pol);
   endtask

   task automatic t_level();
      logic [31:0] d;
      sh_mode = ~32'h4;
      wr(A_SMODE, sh_mode);
      idle(2);
      rd(A_PEND, d); chk("R5 high level inactive", d, 32'h0);
      @(negedge clk); src[2] = 1'b1;
      idle(5);
      rd(A_PEND, d); chk("R5 high level active", d, 32'h4);
      wr(A_PEND, 32'h4);
      idle(1);
      rd(A_PEND, d); chk("R5 clear no lasting effect", d, 32'h4);
      @(negedge clk); src[2] = 1'b0;
      idle(5);
      rd(A_PEND, d); chk("R5 level follows release", d, 32'h0);
      sh_pol = ~32'h4;
      wr(A_SPOL, sh_pol);
      idle(2);
      rd(A_PEND, d); chk("R5 active-low level asserted", d, 32'h4);
      @(negedge clk); src[2] = 1'b1;
      idle(5);
      rd(A_PEND, d); chk("R5 active-low level released", d, 32'h0);
      sh_pol = 32'hFFFF_FFFF;
      wr(A_SPOL, sh_pol);
      @(negedge clk); src[2] = 1'b0;
      idle(5);
   endtask

   task automatic t_force();
      logic [31:0] d;
      wr(A_FORCE, 32'h20);
      rd(A_FORCE, d); chk("R10 force readback", d, 32'h20);
      idle(2);
      rd(A_PEND, d); chk("R6 force sets pending", d, 32'h20);
      wr(A_PEND, 32'h20);
      rd(A_PEND, d); chk("R6 force overrides clear", d, 32'h20);
      wr(A_FORCE, 32'h0);
      idle(2);
      rd(A_PEND, d); chk("R6 edge bit holds after force", d, 32'h20);
      wr(A_PEND, 32'h20);
      rd(A_PEND, d); chk("R6 cleared after force removed", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      @(negedge clk); src[0] = 1'b1;
      idle(2);
      @(negedge clk); src[0] = 1'b0;
      idle(5);
      rd(A_PEND, d); chk("R7 pending while masked", d, 32'h1);
      chk("R7 masked line idle", {31'h0, irq_o}, 32'h1);
      wr(A_EN, 32'h2);
      idle(3); #1;
      chk("R7 other enable does not pass", {31'h0, irq_o}, 32'h1);
      wr(A_EN, 32'h1);
      idle(3); #1;
      chk("R7 enabled bit drives line", {31'h0, irq_o}, 32'h0);
      wr(A_PEND, 32'h1);
      idle(3); #1;
      chk("R7 line idle after clear", {31'h0, irq_o}, 32'h1);
      wr(A_EN, 32'h0);
   endtask

   task automatic t_out_level();
      wr(A_EN, 32'h1);
      wr(A_OPOL, 32'h1);
      idle(3); #1;
      chk("R8 active-high idle", {31'h0, irq_o}, 32'h0);
      wr(A_FORCE, 32'h1);
      idle(3); #1;
      chk("R8 active-high asserted", {31'h0, irq_o}, 32'h1);
      wr(A_FORCE, 32'h0);
      wr(A_PEND, 32'h1);
      idle(3); #1;
      chk("R8 active-high released", {31'h0, irq_o}, 32'h0);
      wr(A_OPOL, 32'h0);
      wr(A_EN, 32'h0);
      idle(3);
   endtask

   task automatic t_out_edge();
      int c;
      wr(A_EN, 32'h3);
      wr(A_OPOL, 32'h1);
      wr(A_OMODE, 32'h1);
      idle(3);
      wr(A_FORCE, 32'h1);
      count_level(10, 1'b1, c);
      chk("R9 one pulse on rise", c, 1);
      wr(A_FORCE, 32'h3);
      count_level(10, 1'b1, c);
      chk("R9 no pulse while request stays high", c, 0);
      wr(A_FORCE, 32'h0);
      wr(A_PEND, 32'h3);
      idle(3);
      wr(A_FORCE, 32'h2);
      count_level(10, 1'b1, c);
      chk("R9 new rise pulses again", c, 1);
      wr(A_FORCE, 32'h0);
      wr(A_PEND, 32'h3);
      wr(A_OPOL, 32'h0);
      idle(3);
      wr(A_FORCE, 32'h1);
      count_level(10, 1'b0, c);
      chk("R9 active-low pulse", c, 1);
      wr(A_FORCE, 32'h0);
      wr(A_PEND, 32'h3);
      wr(A_OMODE, 32'h0);
      wr(A_EN, 32'h0);
      idle(3);
   endtask

   initial begin
      #500us;
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      sh_mode = 32'hFFFF_FFFF;
      sh_pol  = 32'hFFFF_FFFF;
      idle(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      wr(A_SMODE, sh_mode);
      wr(A_SPOL, sh_pol);
      idle(4);
      wr(A_PEND, 32'hFFFF_FFFF);
      t_readback();
      t_sync_and_edge();
      t_falling();
      t_level();
      t_force();
      t_enable();
      t_out_level();
      t_out_edge();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule